// File: doc/BRIEF.md
# CPU exception entry controller

This block performs the state changes a small 32-bit processor makes when it takes an exception. Each cause that wants service sets one bit of a pending vector. In each cycle the controller picks the lowest-numbered pending cause and saves the current program counter into one of two link registers. It moves the global interrupt enable into one of two shadow bits and clears the enable. On the next clock edge it pulses a redirect that carries the handler address.

There are two classes of exception. Breakpoint (cause 1) and watchpoint (cause 3) are debug exceptions. Instruction bus error (2), data bus error (4), divide by zero (5), interrupt (6) and system call (7) are normal exceptions. Cause 0 is the reset slot and cannot be requested. Every cause owns a 32-byte slot above a vector base. Debug exceptions always use the debug base. Normal exceptions use the normal base, and they use the debug base instead while the remap bit is set. Software reaches the enable bits, the remap bit, both link registers and both bases through simple write ports. Two return strobes restore the enable from the matching shadow bit.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Bit i of `exc_pend` (i = 1..7) requests cause i. When any bit is set on a clock edge, the lowest-numbered set bit is taken and `cause_out` shows its index from the next cycle on.
- R2: Causes 1 and 3 are debug exceptions. Causes 2, 4, 5, 6 and 7 are normal exceptions.
- R3: A normal exception stores `pc_in` into `ea_o` and leaves `ba_o` unchanged.
- R4: A debug exception stores `pc_in` into `ba_o` and leaves `ea_o` unchanged.
- R5: A normal exception copies the prior `ie_o` into `eie_o` and clears `ie_o`. `bie_o` keeps its value.
- R6: A debug exception copies the prior `ie_o` into `bie_o` and clears `ie_o`. `eie_o` keeps its value.
- R7: `redirect_pc` equals base + 32 × cause. The base is `deba_o` for debug exceptions. For normal exceptions it is `eba_o`, or `deba_o` when `re_o` is 1.
- R8: Bits 7:0 of `eba_o` and `deba_o` always read zero, whatever value is written to them.
- R9: When `eret_stb` is pulsed with no exception pending, `ie_o` takes the value of `eie_o`. When `bret_stb` is pulsed with no exception pending, `ie_o` takes the value of `bie_o`.
- R10: While `rst_n` is low, `ie_o`, `eie_o`, `bie_o`, `re_o`, `ea_o`, `ba_o` and `redirect` are 0. `eba_o` and `deba_o` hold RESET_BASE with bits 7:0 cleared.
- R11: `redirect` is high for exactly the cycle that follows each edge on which some request bit was set. A cycle with no request changes neither `ie_o` nor the link registers, and it leaves `redirect` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_pend | input | 7 | Pending causes, bit i is cause i (bits 7:1) |
| pc_in | input | 32 | Program counter of the excepting instruction |
| eret_stb | input | 1 | Return from a normal exception: ie from eie |
| bret_stb | input | 1 | Return from a debug exception: ie from bie |
| ie_we | input | 1 | Write strobe for the enable bits |
| ie_wd | input | 3 | Enable write data {bie, eie, ie} |
| dc_we | input | 1 | Write strobe for the remap bit |
| dc_wd | input | 1 | Remap bit write data |
| reg_we | input | 4 | Register write strobes {deba, eba, ba, ea} |
| reg_wd | input | 32 | Register write data |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Handler address |
| cause_out | output | 3 | Index of the cause taken |
| ie_o | output | 1 | Global interrupt enable |
| eie_o | output | 1 | Enable shadow for normal exceptions |
| bie_o | output | 1 | Enable shadow for debug exceptions |
| re_o | output | 1 | Remap normal exceptions onto the debug base |
| ea_o | output | 32 | Normal-exception return address |
| ba_o | output | 32 | Debug-exception return address |
| eba_o | output | 32 | Normal vector base |
| deba_o | output | 32 | Debug vector base |

## Verification
On every redirect, the assertions check four things. The reported cause must be the lowest bit that was pending. The enable must be clear, and the correct shadow bit must hold the enable value from before the exception. The correct link register must hold the sampled program counter, and the handler address must put the cause in its slot field with the low five bits zero. Which base was selected, that the other link register and the other shadow bit are left alone, the masking of the base registers, the return strobes and the reset values are shown only by the bench. Its sweep covers every pending pattern for each combination of prior enable and remap bit.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int NCAUSE = 8,
  parameter int CW = $clog2(NCAUSE),
  parameter int SLOT_LG = 5,
  parameter int BASE_LO = 8,
  parameter logic [NCAUSE-1:0] DBG_MASK = 8'b0000_1010,
  parameter logic [XLEN-1:0] RESET_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:1] exc_pend,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              eret_stb,
  input  logic              bret_stb,
  input  logic              ie_we,
  input  logic [2:0]        ie_wd,
  input  logic              dc_we,
  input  logic              dc_wd,
  input  logic [3:0]        reg_we,
  input  logic [XLEN-1:0]   reg_wd,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [CW-1:0]     cause_out,
  output logic              ie_o,
  output logic              eie_o,
  output logic              bie_o,
  output logic              re_o,
  output logic [XLEN-1:0]   ea_o,
  output logic [XLEN-1:0]   ba_o,
  output logic [XLEN-1:0]   eba_o,
  output logic [XLEN-1:0]   deba_o
);
  localparam logic [XLEN-1:0] HI_MASK = ~((XLEN'(1) << BASE_LO) - XLEN'(1));

  logic [CW-1:0]   sel;
  logic            hit;
  logic            is_dbg;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] vec;

  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int i = NCAUSE - 1; i >= 1; i--) begin
      if (exc_pend[i]) begin
        sel = CW'(i);
        hit = 1'b1;
      end
    end
  end

  assign is_dbg = DBG_MASK[sel];
  assign base   = (is_dbg || re_o) ? deba_o : eba_o;
  assign vec    = base | (XLEN'(sel) << SLOT_LG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_o  <= 1'b0;
      eie_o <= 1'b0;
      bie_o <= 1'b0;
    end else if (hit) begin
      ie_o <= 1'b0;
      if (is_dbg) bie_o <= ie_o;
      else        eie_o <= ie_o;
    end else if (eret_stb) begin
      ie_o <= eie_o;
    end else if (bret_stb) begin
      ie_o <= bie_o;
    end else if (ie_we) begin
      {bie_o, eie_o, ie_o} <= ie_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_o   <= 1'b0;
      ea_o   <= '0;
      ba_o   <= '0;
      eba_o  <= RESET_BASE & HI_MASK;
      deba_o <= RESET_BASE & HI_MASK;
    end else begin
      if (dc_we) re_o <= dc_wd;
      if (hit && !is_dbg) ea_o <= pc_in;
      else if (reg_we[0]) ea_o <= reg_wd;
      if (hit && is_dbg)  ba_o <= pc_in;
      else if (reg_we[1]) ba_o <= reg_wd;
      if (reg_we[2]) eba_o  <= reg_wd & HI_MASK;
      if (reg_we[3]) deba_o <= reg_wd & HI_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      cause_out   <= '0;
    end else begin
      redirect <= hit;
      if (hit) begin
        redirect_pc <= vec;
        cause_out   <= sel;
      end
    end
  end
endmodule

module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int NCAUSE = 8,
  parameter int CW = 3,
  parameter int SLOT_LG = 5,
  parameter logic [NCAUSE-1:0] DBG_MASK = 8'b0000_1010
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCAUSE-1:1] exc_pend,
  input logic [XLEN-1:0]   pc_in,
  input logic              redirect,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [CW-1:0]     cause_out,
  input logic              ie_o,
  input logic              eie_o,
  input logic              bie_o,
  input logic [XLEN-1:0]   ea_o,
  input logic [XLEN-1:0]   ba_o
);
  logic [NCAUSE-1:0] pend_q;
  logic [NCAUSE-1:0] below;
  logic              dbg_now;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= {exc_pend, 1'b0};
  end

  assign below   = (NCAUSE'(1) << cause_out) - NCAUSE'(1);
  assign dbg_now = DBG_MASK[cause_out];

  assert_taken_lowest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (pend_q[cause_out] && ((pend_q & below) == '0)));
  assert_pulse_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (pend_q != '0));
  assert_ie_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !ie_o);
  assert_eie_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !dbg_now) |-> (eie_o == $past(ie_o)));
  assert_bie_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && dbg_now) |-> (bie_o == $past(ie_o)));
  assert_ea_saved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !dbg_now) |-> (ea_o == $past(pc_in)));
  assert_ba_saved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && dbg_now) |-> (ba_o == $past(pc_in)));
  assert_slot_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ((redirect_pc[SLOT_LG +: CW] == cause_out) && (redirect_pc[SLOT_LG-1:0] == '0)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .NCAUSE(NCAUSE), .CW(CW), .SLOT_LG(SLOT_LG), .DBG_MASK(DBG_MASK)
) u_chk (.*);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
  localparam logic [31:0] RB   = 32'h4000_0080;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [31:0] EBA  = 32'h1234_5600;
  localparam logic [31:0] DEBA = 32'h8000_0700;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:1]  exc_pend;
  logic [31:0] pc_in;
  logic        eret_stb, bret_stb, ie_we, dc_we, dc_wd;
  logic [2:0]  ie_wd;
  logic [3:0]  reg_we;
  logic [31:0] reg_wd;
  logic        redirect, ie_o, eie_o, bie_o, re_o;
  logic [31:0] redirect_pc, ea_o, ba_o, eba_o, deba_o;
  logic [2:0]  cause_out;

  int nvec = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl #(.RESET_BASE(RB)) i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_pend(exc_pend), .pc_in(pc_in),
    .eret_stb(eret_stb), .bret_stb(bret_stb), .ie_we(ie_we), .ie_wd(ie_wd),
    .dc_we(dc_we), .dc_wd(dc_wd), .reg_we(reg_we), .reg_wd(reg_wd),
    .redirect(redirect), .redirect_pc(redirect_pc), .cause_out(cause_out),
    .ie_o(ie_o), .eie_o(eie_o), .bie_o(bie_o), .re_o(re_o),
    .ea_o(ea_o), .ba_o(ba_o), .eba_o(eba_o), .deba_o(deba_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] pcv;
    rst_n = 0; exc_pend = '0; pc_in = '0; eret_stb = 0; bret_stb = 0;
    ie_we = 0; ie_wd = '0; dc_we = 0; dc_wd = 0; reg_we = '0; reg_wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ie", {31'd0, ie_o}, 0);
    chk("R10 eie/bie", {30'd0, eie_o, bie_o}, 0);
    chk("R10 re", {31'd0, re_o}, 0);
    chk("R10 redirect", {31'd0, redirect}, 0);
    chk("R10 ea", ea_o, 0);
    chk("R10 ba", ba_o, 0);
    chk("R10 eba", eba_o, 32'h4000_0000);
    chk("R10 deba", deba_o, 32'h4000_0000);
    rst_n = 1;

    reg_we = 4'b0100; reg_wd = 32'h1234_56FF;
    @(negedge clk);
    reg_we = 4'b1000; reg_wd = 32'h8000_07AB;
    @(negedge clk);
    reg_we = 4'b0000;
    chk("R8 eba low bits", eba_o, EBA);
    chk("R8 deba low bits", deba_o, DEBA);

    for (int iev = 0; iev < 2; iev++) begin
      for (int rev = 0; rev < 2; rev++) begin
        for (int p = 0; p < 128; p++) begin
          int idx;
          logic dbg;
          logic [31:0] expc;
          @(negedge clk);
          ie_we = 1; ie_wd = {2'b00, iev[0]}; dc_we = 1; dc_wd = rev[0];
          reg_we = 4'b0011; reg_wd = SENT;
          pcv = $random & 32'hFFFF_FFFC;
          @(negedge clk);
          ie_we = 0; dc_we = 0; reg_we = 0;
          exc_pend = p[6:0]; pc_in = pcv;
          @(posedge clk); #1;
          exc_pend = '0;
          idx = 0;
          for (int i = 1; i < 8; i++) if (p[i-1] && idx == 0) idx = i;
          dbg = (idx == 1) || (idx == 3);
          chk("R11 redirect", {31'd0, redirect}, {31'd0, (p != 0)});
          if (p != 0) begin
            chk("R1 cause", {29'd0, cause_out}, idx);
            expc = ((dbg || rev[0]) ? DEBA : EBA) + 32'(idx * 32);
            chk("R7 vector", redirect_pc, expc);
            chk("R5 R6 ie cleared", {31'd0, ie_o}, 0);
            if (dbg) begin
              chk("R2 R4 ba", ba_o, pcv);
              chk("R4 ea kept", ea_o, SENT);
              chk("R6 bie", {31'd0, bie_o}, iev);
              chk("R6 eie kept", {31'd0, eie_o}, 0);
            end else begin
              chk("R2 R3 ea", ea_o, pcv);
              chk("R3 ba kept", ba_o, SENT);
              chk("R5 eie", {31'd0, eie_o}, iev);
              chk("R5 bie kept", {31'd0, bie_o}, 0);
            end
          end else begin
            chk("R11 ie kept", {31'd0, ie_o}, iev);
            chk("R11 ea kept", ea_o, SENT);
            chk("R11 ba kept", ba_o, SENT);
          end
          @(posedge clk); #1;
          chk("R11 single pulse", {31'd0, redirect}, 0);
        end
      end
    end

    @(negedge clk);
    ie_we = 1; ie_wd = 3'b001; dc_we = 1; dc_wd = 0;
    @(negedge clk);
    ie_we = 0; dc_we = 0; exc_pend = 7'b010_0000;
    @(negedge clk);
    exc_pend = '0;
    chk("R5 eie set before eret", {30'd0, eie_o, ie_o}, 32'd2);
    eret_stb = 1;
    @(negedge clk);
    eret_stb = 0;
    chk("R9 eret restores ie", {31'd0, ie_o}, 1);

    ie_we = 1; ie_wd = 3'b100;
    @(negedge clk);
    ie_we = 0; bret_stb = 1;
    @(negedge clk);
    bret_stb = 0;
    chk("R9 bret restores ie=1", {31'd0, ie_o}, 1);

    ie_we = 1; ie_wd = 3'b011;
    @(negedge clk);
    ie_we = 0; bret_stb = 1;
    @(negedge clk);
    bret_stb = 0;
    chk("R9 bret restores ie=0", {31'd0, ie_o}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule